// File: doc/BRIEF.md
# Dual-Channel Keyboard and Power-Management Host Mailbox

This block sits between a PC host I/O bus and embedded firmware. It provides two independent byte mailboxes. Channel 0 serves the legacy keyboard controller and carries both keyboard and auxiliary-device (mouse) bytes. Channel 1 serves power management. Each channel gives the host a data port and a command/status port. A host write to either port fills the channel's input buffer. A firmware write fills the channel's output buffer, which the host drains by reading the data port.

The host address decoder compares against two base-address inputs that can be changed at run time. The data port sits at the base address and the command/status port at the base plus 4, so bases 60h and 62h give the usual 60h/64h and 62h/66h pairs. The firmware side is a plain four-register port, selected by `fw_sel` and `fw_addr`. Channel 0 register 3 also holds a level-controlled gate-A20 output and the trigger for a fixed-length fast host-reset pulse.

Host and firmware accesses are single-cycle strobes. Read data is combinational in the strobe cycle, and every side effect of an access lands on the clock edge that ends that cycle. There is no back-pressure. A host write into a full input buffer overwrites it, and a firmware write into a full output buffer overwrites it.

Top module: `kbd_host_mailbox`

## Requirements
- R1: On channel c, the data port decodes at host address base_c and the command/status port at base_c+4. `host_hit` is 1 only on such an address, and `host_rdata` is 0 when no port matches. If both channels match the same address, channel 0 wins.
- R2: A host write to a data or command port loads the input buffer and sets input-full. It sets the command flag on a command-port write and clears it on a data-port write.
- R3: A firmware read of register 0 returns the input buffer and clears input-full at the end of that cycle. The command flag is left as it was.
- R4: A firmware write to register 0 (keyboard byte) or register 1 (auxiliary byte) loads the output buffer and sets output-full. It sets the auxiliary flag to 0 for register 0 and 1 for register 1. A host read of the data port returns the output buffer and clears output-full.
- R5: The status byte, read by the host at the command port or by firmware at register 1, is: bit0 output-full, bit1 input-full, bit2 system flag, bit3 command flag, bit5 auxiliary flag, all other bits 0.
- R6: `irq_kbd` = channel 0 output-full with auxiliary flag 0. `irq_aux` = channel 0 output-full with auxiliary flag 1. `irq_pm` = channel 1 output-full.
- R7: A firmware write to register 2 sets that channel's system flag to bit 0 of the written byte.
- R8: In a single cycle, a firmware output write beats a host data read, so output-full stays set. A host write beats a firmware input read, so input-full stays set.
- R9: A firmware write to channel 0 register 3 sets `gate_a20` to bit 0 of the written byte. No other access changes `gate_a20`.
- R10: A write to channel 0 register 3 with bit 1 set drives `host_rst_out` high for exactly RST_LEN cycles, starting in the next cycle. A new trigger during a pulse restarts the count.
- R11: After reset, all flags, buffers, interrupts, `gate_a20` and `host_rst_out` are 0.
- R12: A change to a base-address input moves that channel's ports from the next access onward. The old address then stops decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kbc_base | input | 16 | Keyboard channel base I/O address |
| pm_base | input | 16 | Power-management channel base I/O address |
| host_addr | input | 16 | Host I/O address |
| host_rd | input | 1 | Host read strobe, one cycle |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, combinational |
| host_hit | output | 1 | Host address matches a port |
| fw_sel | input | 1 | Firmware channel select |
| fw_addr | input | 2 | Firmware register select |
| fw_rd | input | 1 | Firmware read strobe |
| fw_wr | input | 1 | Firmware write strobe |
| fw_wdata | input | 8 | Firmware write byte |
| fw_rdata | output | 8 | Firmware read byte, combinational |
| irq_kbd | output | 1 | Keyboard byte waiting |
| irq_aux | output | 1 | Auxiliary byte waiting |
| irq_pm | output | 1 | Power-management byte waiting |
| gate_a20 | output | 1 | Gate-A20 level |
| host_rst_out | output | 1 | Fast host reset pulse |

## Verification
A stuck or wrongly updated buffer flag shows up at the ports on the very next host status read. It also shows on the interrupt pins in the cycle after the access that should have changed it. A wrong auxiliary flag moves the interrupt from one pin to the other in that same cycle. A reset counter that is off by one makes the pulse one cycle short or long, which a cycle count of the pulse catches. Decode errors show as data returned at an unmapped address, or as a missing `host_hit`.

// File: rtl/kbm_pkg.sv
package kbm_pkg;
  localparam int NCH    = 2;
  localparam int BYTE_W = 8;

  localparam logic [1:0] FW_REG_BUF  = 2'd0;
  localparam logic [1:0] FW_REG_AUX  = 2'd1;
  localparam logic [1:0] FW_REG_SYS  = 2'd2;
  localparam logic [1:0] FW_REG_CTRL = 2'd3;

  function automatic logic [BYTE_W-1:0] pack_status(input logic obf, input logic ibf,
                                                     input logic sys, input logic cmd,
                                                     input logic aux);
    logic [BYTE_W-1:0] s;
    s = '0;
    s[0] = obf;
    s[1] = ibf;
    s[2] = sys;
    s[3] = cmd;
    s[5] = aux;
    return s;
  endfunction
endpackage

// File: rtl/kbm_addr_dec.sv
module kbm_addr_dec #(
  parameter int ADDR_W  = 16,
  parameter int CMD_OFS = 4
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] addr,
  output logic              data_hit,
  output logic              cmd_hit
);
  localparam logic [ADDR_W-1:0] OFS = ADDR_W'(CMD_OFS);
  logic [ADDR_W-1:0] cmd_addr;

  always_comb begin
    cmd_addr = base + OFS;
    data_hit = (addr == base);
    cmd_hit  = (addr == cmd_addr);
  end
endmodule

// File: rtl/kbm_channel.sv
module kbm_channel
  import kbm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_wr_data,
  input  logic              h_wr_cmd,
  input  logic              h_rd_data,
  input  logic [BYTE_W-1:0] h_wdata,
  input  logic              f_rd_in,
  input  logic              f_wr_out,
  input  logic              f_wr_aux,
  input  logic              f_wr_sys,
  input  logic [BYTE_W-1:0] f_wdata,
  output logic [BYTE_W-1:0] in_byte,
  output logic [BYTE_W-1:0] out_byte,
  output logic [BYTE_W-1:0] status,
  output logic              obf,
  output logic              ibf,
  output logic              aux
);
  logic sys_q, cmd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_byte  <= '0;
      out_byte <= '0;
      ibf      <= 1'b0;
      obf      <= 1'b0;
      aux      <= 1'b0;
      cmd_q    <= 1'b0;
      sys_q    <= 1'b0;
    end else begin
      if (h_wr_data || h_wr_cmd) begin
        in_byte <= h_wdata;
        ibf     <= 1'b1;
        cmd_q   <= h_wr_cmd;
      end else if (f_rd_in) begin
        ibf <= 1'b0;
      end
      if (f_wr_out) begin
        out_byte <= f_wdata;
        obf      <= 1'b1;
        aux      <= f_wr_aux;
      end else if (h_rd_data) begin
        obf <= 1'b0;
      end
      if (f_wr_sys) sys_q <= f_wdata[0];
    end
  end

  assign status = pack_status(obf, ibf, sys_q, cmd_q, aux);
endmodule

// File: rtl/kbm_fast_reset.sv
module kbm_fast_reset #(
  parameter int RST_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic pulse
);
  localparam int CW = $clog2(RST_LEN + 1);
  localparam logic [CW-1:0] LOAD = CW'(RST_LEN);
  logic [CW-1:0] left;

  always_ff @(posedge clk) begin
    if (!rst_n)               left <= '0;
    else if (start)           left <= LOAD;
    else if (left != '0)      left <= left - 1'b1;
  end

  assign pulse = (left != '0);
endmodule

// File: rtl/kbd_host_mailbox.sv
module kbd_host_mailbox
  import kbm_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int CMD_OFS = 4,
  parameter int RST_LEN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] kbc_base,
  input  logic [ADDR_W-1:0] pm_base,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  output logic              host_hit,
  input  logic              fw_sel,
  input  logic [1:0]        fw_addr,
  input  logic              fw_rd,
  input  logic              fw_wr,
  input  logic [7:0]        fw_wdata,
  output logic [7:0]        fw_rdata,
  output logic              irq_kbd,
  output logic              irq_aux,
  output logic              irq_pm,
  output logic              gate_a20,
  output logic              host_rst_out
);
  logic [ADDR_W-1:0] base_v [NCH];
  logic [NCH-1:0]    d_raw, c_raw, d_hit, c_hit;
  logic [NCH-1:0]    ch_obf, ch_ibf, ch_aux;
  logic [7:0]        ch_in [NCH];
  logic [7:0]        ch_out [NCH];
  logic [7:0]        ch_st [NCH];
  logic              a20_q, rst_go, ctrl_wr;

  assign base_v[0] = kbc_base;
  assign base_v[1] = pm_base;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic fsel;
    kbm_addr_dec #(.ADDR_W(ADDR_W), .CMD_OFS(CMD_OFS)) u_dec (
      .base(base_v[c]), .addr(host_addr),
      .data_hit(d_raw[c]), .cmd_hit(c_raw[c])
    );
    if (c == 0) begin : g_first
      assign d_hit[c] = d_raw[c];
      assign c_hit[c] = c_raw[c] & ~d_raw[c];
    end else begin : g_rest
      assign d_hit[c] = d_raw[c] & ~(|d_hit[c-1:0]) & ~(|c_hit[c-1:0]);
      assign c_hit[c] = c_raw[c] & ~d_raw[c] & ~(|d_hit[c-1:0]) & ~(|c_hit[c-1:0]);
    end
    assign fsel = (fw_sel == 1'(c));
    kbm_channel u_ch (
      .clk(clk), .rst_n(rst_n),
      .h_wr_data(host_wr & d_hit[c]),
      .h_wr_cmd(host_wr & c_hit[c]),
      .h_rd_data(host_rd & d_hit[c]),
      .h_wdata(host_wdata),
      .f_rd_in(fw_rd & fsel & (fw_addr == FW_REG_BUF)),
      .f_wr_out(fw_wr & fsel & ((fw_addr == FW_REG_BUF) | (fw_addr == FW_REG_AUX))),
      .f_wr_aux(fw_addr == FW_REG_AUX),
      .f_wr_sys(fw_wr & fsel & (fw_addr == FW_REG_SYS)),
      .f_wdata(fw_wdata),
      .in_byte(ch_in[c]), .out_byte(ch_out[c]), .status(ch_st[c]),
      .obf(ch_obf[c]), .ibf(ch_ibf[c]), .aux(ch_aux[c])
    );
  end

  always_comb begin
    host_rdata = '0;
    for (int c = 0; c < NCH; c++) begin
      if (d_hit[c]) host_rdata = ch_out[c];
      if (c_hit[c]) host_rdata = ch_st[c];
    end
  end
  assign host_hit = |(d_hit | c_hit);

  assign ctrl_wr = fw_wr & (fw_sel == 1'b0) & (fw_addr == FW_REG_CTRL);
  assign rst_go  = ctrl_wr & fw_wdata[1];

  always_ff @(posedge clk) begin
    if (!rst_n)       a20_q <= 1'b0;
    else if (ctrl_wr) a20_q <= fw_wdata[0];
  end

  kbm_fast_reset #(.RST_LEN(RST_LEN)) u_rst (
    .clk(clk), .rst_n(rst_n), .start(rst_go), .pulse(host_rst_out)
  );

  always_comb begin
    unique case (fw_addr)
      FW_REG_BUF:  fw_rdata = ch_in[fw_sel];
      FW_REG_AUX:  fw_rdata = ch_st[fw_sel];
      FW_REG_SYS:  fw_rdata = {7'b0, ch_st[fw_sel][2]};
      default:     fw_rdata = fw_sel ? 8'h00 : {6'b0, host_rst_out, a20_q};
    endcase
  end

  assign gate_a20 = a20_q;
  assign irq_kbd  = ch_obf[0] & ~ch_aux[0];
  assign irq_aux  = ch_obf[0] &  ch_aux[0];
  assign irq_pm   = ch_obf[1];
endmodule

// File: rtl/kbm_checker.sv
module kbm_checker #(
  parameter int RST_LEN = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       host_wr,
  input logic       host_hit,
  input logic [7:0] host_rdata,
  input logic [1:0] ch_ibf,
  input logic       fw_sel,
  input logic [1:0] fw_addr,
  input logic       fw_wr,
  input logic [7:0] fw_wdata,
  input logic       irq_kbd,
  input logic       irq_aux,
  input logic       irq_pm,
  input logic       gate_a20,
  input logic       host_rst_out
);
  localparam int CW = $clog2(RST_LEN + 2) + 1;
  logic [CW-1:0] run;
  logic trig, ctrl;

  assign ctrl = fw_wr && !fw_sel && fw_addr == 2'd3;
  assign trig = ctrl && fw_wdata[1];

  always_ff @(posedge clk) begin
    if (!rst_n)            run <= '0;
    else if (trig)         run <= '0;
    else if (host_rst_out) run <= run + 1'b1;
    else                   run <= '0;
  end

  AST_NO_HIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !host_hit |-> host_rdata == 8'h00); // R1
  AST_IBF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && host_hit |=> |ch_ibf); // R2
  AST_OBF_KBD: assert property (@(posedge clk) disable iff (!rst_n)
    fw_wr && !fw_sel && fw_addr == 2'd0 |=> irq_kbd && !irq_aux); // R4
  AST_OBF_PM: assert property (@(posedge clk) disable iff (!rst_n)
    fw_wr && fw_sel && fw_addr[1] == 1'b0 |=> irq_pm); // R6
  AST_A20_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl |=> $stable(gate_a20)); // R9
  AST_RST_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    run <= CW'(RST_LEN)); // R10
  AST_RST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_rst_out) |-> $past(trig)); // R10
endmodule

bind kbd_host_mailbox kbm_checker #(.RST_LEN(RST_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_hit(host_hit),
  .host_rdata(host_rdata), .ch_ibf(ch_ibf), .fw_sel(fw_sel), .fw_addr(fw_addr),
  .fw_wr(fw_wr), .fw_wdata(fw_wdata), .irq_kbd(irq_kbd), .irq_aux(irq_aux),
  .irq_pm(irq_pm), .gate_a20(gate_a20), .host_rst_out(host_rst_out)
);

// File: tb/sim_kbd_host_mailbox.sv
module sim_kbd_host_mailbox;
  localparam int RST_LEN = 8;
  logic clk = 0, rst_n = 0;
  logic [15:0] kbc_base = 16'h0060, pm_base = 16'h0062, host_addr = '0;
  logic host_rd = 0, host_wr = 0, fw_sel = 0, fw_rd = 0, fw_wr = 0;
  logic [7:0] host_wdata = '0, fw_wdata = '0, host_rdata, fw_rdata;
  logic [1:0] fw_addr = '0;
  logic host_hit, irq_kbd, irq_aux, irq_pm, gate_a20, host_rst_out;
  int checks = 0, errors = 0;
  logic [7:0] rv;

  always #5 clk = ~clk;

  kbd_host_mailbox #(.RST_LEN(RST_LEN)) u0 (.*);

  // op: 0 host write, 1 host read, 2 fw write, 3 fw read
  // host tgt: 0=60h 1=64h 2=62h 3=66h ; fw tgt: {ch, reg}
  localparam logic [23:0] VEC [25] = '{
    {4'd1,4'd1,8'h00,8'h00}, {4'd0,4'd1,8'hD1,8'h00}, {4'd1,4'd1,8'h00,8'h0A},
    {4'd3,4'd0,8'h00,8'hD1}, {4'd1,4'd1,8'h00,8'h08}, {4'd0,4'd0,8'h55,8'h00},
    {4'd1,4'd1,8'h00,8'h02}, {4'd3,4'd0,8'h00,8'h55}, {4'd2,4'd0,8'hFA,8'h00},
    {4'd1,4'd1,8'h00,8'h01}, {4'd1,4'd0,8'h00,8'hFA}, {4'd1,4'd1,8'h00,8'h00},
    {4'd2,4'd1,8'h33,8'h00}, {4'd1,4'd1,8'h00,8'h21}, {4'd1,4'd0,8'h00,8'h33},
    {4'd2,4'd2,8'h01,8'h00}, {4'd1,4'd1,8'h00,8'h24}, {4'd0,4'd3,8'h81,8'h00},
    {4'd1,4'd3,8'h00,8'h0A}, {4'd1,4'd1,8'h00,8'h24}, {4'd3,4'd4,8'h00,8'h81},
    {4'd2,4'd4,8'h9C,8'h00}, {4'd1,4'd3,8'h00,8'h09}, {4'd1,4'd2,8'h00,8'h9C},
    {4'd3,4'd5,8'h00,8'h08}
  };
  localparam string VTAG [25] = '{
    "R11","R2","R2","R3","R3","R2","R5","R3","R4","R5","R4","R4","R4",
    "R5","R4","R7","R7","R1","R2","R1","R3","R4","R5","R4","R5"};

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic host_op(input logic [15:0] a, input logic wr, input logic [7:0] d,
                         output logic [7:0] r);
    @(negedge clk);
    host_addr = a; host_wr = wr; host_rd = !wr; host_wdata = d;
    #1 r = host_rdata;
    @(posedge clk); #1;
    host_wr = 0; host_rd = 0;
  endtask

  task automatic fw_op(input logic ch, input logic [1:0] a, input logic wr,
                       input logic [7:0] d, output logic [7:0] r);
    @(negedge clk);
    fw_sel = ch; fw_addr = a; fw_wr = wr; fw_rd = !wr; fw_wdata = d;
    #1 r = fw_rdata;
    @(posedge clk); #1;
    fw_wr = 0; fw_rd = 0;
  endtask

  function automatic logic [15:0] haddr(input logic [3:0] t);
    case (t[1:0])
      2'd0: return 16'h0060;
      2'd1: return 16'h0064;
      2'd2: return 16'h0062;
      default: return 16'h0066;
    endcase
  endfunction

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check("R11 irq/a20/rst", {3'b0, irq_kbd, irq_aux, irq_pm, gate_a20, host_rst_out}, 8'h00);

    for (int i = 0; i < 25; i++) begin
      logic [23:0] v;
      v = VEC[i];
      case (v[23:20])
        4'd0: host_op(haddr(v[19:16]), 1'b1, v[15:8], rv);
        4'd1: begin host_op(haddr(v[19:16]), 1'b0, 8'h00, rv); check(VTAG[i], rv, v[7:0]); end
        4'd2: fw_op(v[18], v[17:16], 1'b1, v[15:8], rv);
        default: begin fw_op(v[18], v[17:16], 1'b0, 8'h00, rv); check(VTAG[i], rv, v[7:0]); end
      endcase
    end

    // R6 interrupt routing
    fw_op(1'b0, 2'd0, 1'b1, 8'h11, rv); @(negedge clk);
    check("R6 kbd byte", {5'b0, irq_kbd, irq_aux, irq_pm}, 8'b100);
    fw_op(1'b0, 2'd1, 1'b1, 8'h22, rv); @(negedge clk);
    check("R6 aux byte", {5'b0, irq_kbd, irq_aux, irq_pm}, 8'b010);
    fw_op(1'b1, 2'd0, 1'b1, 8'h44, rv); @(negedge clk);
    check("R6 pm byte", {5'b0, irq_kbd, irq_aux, irq_pm}, 8'b011);
    host_op(16'h0062, 1'b0, 8'h00, rv);
    host_op(16'h0060, 1'b0, 8'h00, rv); @(negedge clk);
    check("R6 drained", {5'b0, irq_kbd, irq_aux, irq_pm}, 8'b000);

    // R8 same-cycle priority, output side
    fw_op(1'b0, 2'd0, 1'b1, 8'hA1, rv);
    @(negedge clk);
    host_addr = 16'h0060; host_rd = 1; fw_sel = 0; fw_addr = 2'd0; fw_wr = 1; fw_wdata = 8'hB2;
    @(posedge clk); #1 host_rd = 0; fw_wr = 0;
    host_op(16'h0064, 1'b0, 8'h00, rv);
    check("R8 obf kept", rv & 8'h01, 8'h01);
    host_op(16'h0060, 1'b0, 8'h00, rv);
    check("R8 new byte", rv, 8'hB2);
    // R8 input side
    @(negedge clk);
    host_addr = 16'h0060; host_wr = 1; host_wdata = 8'h5A; fw_sel = 0; fw_addr = 2'd0; fw_rd = 1;
    @(posedge clk); #1 host_wr = 0; fw_rd = 0;
    host_op(16'h0064, 1'b0, 8'h00, rv);
    check("R8 ibf kept", rv & 8'h02, 8'h02);

    // R1 unmapped address
    host_op(16'h0070, 1'b1, 8'hEE, rv);
    host_op(16'h0070, 1'b0, 8'h00, rv);
    check("R1 unmapped rdata", rv, 8'h00);
    check("R1 unmapped hit", {7'b0, host_hit}, 8'h00);
    fw_op(1'b0, 2'd0, 1'b0, 8'h00, rv);
    check("R1 no write", rv, 8'h5A);

    // R12 base relocation
    kbc_base = 16'h0200;
    host_op(16'h0204, 1'b1, 8'h77, rv);
    fw_op(1'b0, 2'd0, 1'b0, 8'h00, rv);
    check("R12 new base", rv, 8'h77);
    host_op(16'h0064, 1'b0, 8'h00, rv);
    check("R12 old base gone", {7'b0, host_hit}, 8'h00);
    kbc_base = 16'h0060;

    // R9 gate A20
    fw_op(1'b0, 2'd3, 1'b1, 8'h01, rv); @(negedge clk);
    check("R9 a20 on", {7'b0, gate_a20}, 8'h01);
    fw_op(1'b1, 2'd3, 1'b1, 8'h00, rv); @(negedge clk);
    check("R9 ch1 ignored", {7'b0, gate_a20}, 8'h01);

    // R10 reset pulse length
    fw_op(1'b0, 2'd3, 1'b1, 8'h03, rv);
    @(negedge clk); n = 0;
    while (host_rst_out && n < 100) begin n++; @(negedge clk); end
    check("R10 pulse len", 8'(n), 8'(RST_LEN));
    fw_op(1'b0, 2'd3, 1'b1, 8'h03, rv);
    repeat (3) @(negedge clk);
    fw_op(1'b0, 2'd3, 1'b1, 8'h03, rv);
    @(negedge clk); n = 0;
    while (host_rst_out && n < 100) begin n++; @(negedge clk); end
    check("R10 restart len", 8'(n), 8'(RST_LEN));
    check("R9 a20 held", {7'b0, gate_a20}, 8'h01);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule